// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps large, contiguous regions of a 32-bit effective address space onto a 32-bit physical address space without consulting a page table. Software loads a small set of region descriptors. There is one bank for instruction fetches and one bank for loads and stores. Each descriptor holds a logical base, a physical base, an 11-bit size mask, a valid bit for each privilege level and a 2-bit protection code. Region sizes are powers of two, from 128 KB up to 256 MB.

On every clock, the current access is checked against all descriptors of the selected bank in parallel. The access is described by the effective address, the fetch/store/user attributes and the two translation enables. A region matches when the upper 15 address bits agree with the logical base outside the mask. The lowest-numbered matching descriptor supplies the physical address. That address takes its high bits from the physical base where the mask is clear and from the effective address where the mask is set. The unit also reports a hit flag and a protection-violation flag. Results are registered, so they appear one clock after the access is presented.

Top module: `blk_xlate_unit`

## Requirements
- R1: While reset is asserted, `pa`, `hit` and `viol` are 0. After reset, every descriptor is invalid, so a lookup with translation enabled misses.
- R2: When the enable for the access type is 0 (`itr_en` for fetches, `dtr_en` for loads and stores), `pa` equals `ea`, and `hit` and `viol` are 0.
- R3: A descriptor matches when `ea[31:17]` equals its logical base in every bit position whose mask bit (`len` zero-extended to 15 bits) is 0. `len`=0 gives a 128 KB region, 11'h7FF gives 256 MB, and 11'h00F gives 2 MB.
- R4: On a hit, `pa[31:17]` takes the physical-base bits where the mask is 0 and the `ea` bits where the mask is 1.
- R5: `pa[16:0]` always equals `ea[16:0]` of the same access.
- R6: A descriptor can match only if its supervisor-valid bit is set (when `acc_user`=0) or its user-valid bit is set (when `acc_user`=1).
- R7: The protection code is 2'b00 for no access, 2'b01 for read-only, and 2'b10 or 2'b11 for read/write. `viol` is set on a hit to a no-access region, or on a store (`acc_store`=1, `acc_fetch`=0) to a read-only region. A fetch always counts as a read.
- R8: When several descriptors match, the lowest-numbered one supplies the translation.
- R9: Fetches (`acc_fetch`=1) use only the instruction bank. Loads and stores use only the data bank. `wr_side`=1 writes the instruction bank and `wr_side`=0 writes the data bank.
- R10: Outputs reflect the access presented one clock earlier. A descriptor write takes effect for lookups from the clock after the write edge.
- R11: With translation enabled and no match, `pa` equals `ea`, and `hit` and `viol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_side | input | 1 | 1 = instruction bank, 0 = data bank |
| wr_idx | input | IDX_W | Descriptor index to write |
| wr_lbase | input | 15 | Logical base, effective address bits 31:17 |
| wr_pbase | input | 15 | Physical base, physical address bits 31:17 |
| wr_len | input | 11 | Size mask, contiguous low-order ones |
| wr_sv | input | 1 | Supervisor valid |
| wr_uv | input | 1 | User valid |
| wr_prot | input | 2 | Protection code |
| itr_en | input | 1 | Instruction translation enable |
| dtr_en | input | 1 | Data translation enable |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_store | input | 1 | Access is a store (ignored for fetches) |
| acc_user | input | 1 | Access is at user privilege |
| ea | input | 32 | Effective address |
| pa | output | 32 | Physical address (registered) |
| hit | output | 1 | Translation hit (registered) |
| viol | output | 1 | Protection violation (registered) |

## Verification
The assertions assume that software only writes size masks made of contiguous low-order ones. The checker enforces this on every write strobe, and the bench programs only the patterns 0, 3, 15 and 2047. The priority and pass-through properties also assume that the access attributes are steady across each sampling edge. The bench meets this by changing every input at the falling edge and reading the outputs just after the rising edge. The overlapping regions in the bench are chosen so that both the priority rule and the privilege filter decide the outcome of some access.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int EA_W  = 32;
  localparam int OFF_W = 17;
  localparam int LEN_W = 11;
  localparam int TAG_W = EA_W - OFF_W;

  typedef enum logic [1:0] {
    PR_NONE = 2'b00,
    PR_RO   = 2'b01,
    PR_RW   = 2'b10,
    PR_RWX  = 2'b11
  } prot_e;

  typedef struct packed {
    logic [TAG_W-1:0] lbase;
    logic [TAG_W-1:0] pbase;
    logic [LEN_W-1:0] len;
    logic             sv;
    logic             uv;
    prot_e            prot;
  } desc_t;

  // Size mask widened to the tag width; high tag bits are always compared.
  function automatic logic [TAG_W-1:0] tag_mask(input logic [LEN_W-1:0] len);
    return {{(TAG_W-LEN_W){1'b0}}, len};
  endfunction

  function automatic logic len_legal(input logic [LEN_W-1:0] len);
    return ((LEN_W'(len + 1'b1)) & len) == '0;
  endfunction

  function automatic logic region_match(input desc_t d,
                                        input logic [TAG_W-1:0] tag,
                                        input logic user);
    logic ok_priv;
    ok_priv = user ? d.uv : d.sv;
    return ok_priv && (((tag ^ d.lbase) & ~tag_mask(d.len)) == '0);
  endfunction

  function automatic logic [EA_W-1:0] merge_pa(input desc_t d,
                                               input logic [EA_W-1:0] ea);
    logic [TAG_W-1:0] m;
    m = tag_mask(d.len);
    return {(d.pbase & ~m) | (ea[EA_W-1:OFF_W] & m), ea[OFF_W-1:0]};
  endfunction

  function automatic logic access_bad(input prot_e p, input logic store,
                                      input logic fetch);
    logic wr;
    wr = store & ~fetch;
    case (p)
      PR_NONE: return 1'b1;
      PR_RO:   return wr;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bat_desc_bank.sv
module bat_desc_bank
  import bat_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  desc_t                 wr_desc,
  output desc_t [N_ENT-1:0]     descs
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        descs[i] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        descs[i] <= wr_desc;
    end
  end
endmodule

// File: rtl/bat_match.sv
module bat_match
  import bat_pkg::*;
#(
  parameter int N_ENT = 4
) (
  input  desc_t [N_ENT-1:0] descs,
  input  logic [TAG_W-1:0]  tag,
  input  logic              user,
  output logic [N_ENT-1:0]  hit_vec
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hit_vec[i] = region_match(descs[i], tag, user);
  end
endmodule

// File: rtl/bat_prio.sv
module bat_prio #(
  parameter int N_ENT = 4
) (
  input  logic [N_ENT-1:0] hit_vec,
  output logic [N_ENT-1:0] win_vec
);
  always_comb begin
    win_vec = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        win_vec    = '0;
        win_vec[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/blk_xlate_unit.sv
module blk_xlate_unit
  import bat_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_side,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_lbase,
  input  logic [TAG_W-1:0]  wr_pbase,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              wr_sv,
  input  logic              wr_uv,
  input  logic [1:0]        wr_prot,
  input  logic              itr_en,
  input  logic              dtr_en,
  input  logic              acc_fetch,
  input  logic              acc_store,
  input  logic              acc_user,
  input  logic [EA_W-1:0]   ea,
  output logic [EA_W-1:0]   pa,
  output logic              hit,
  output logic              viol
);
  desc_t              wr_desc;
  desc_t [N_ENT-1:0]  ibank;
  desc_t [N_ENT-1:0]  dbank;
  desc_t [N_ENT-1:0]  bank_sel;
  desc_t              win_desc;
  logic [N_ENT-1:0]   hit_vec;
  logic [N_ENT-1:0]   win_vec;
  logic               xon;
  logic               any_hit;
  logic [EA_W-1:0]    pa_nxt;
  logic               viol_nxt;

  assign wr_desc = '{lbase: wr_lbase, pbase: wr_pbase, len: wr_len,
                     sv: wr_sv, uv: wr_uv, prot: prot_e'(wr_prot)};

  bat_desc_bank #(.N_ENT(N_ENT)) u_ibank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en & wr_side), .wr_idx(wr_idx),
    .wr_desc(wr_desc), .descs(ibank)
  );

  bat_desc_bank #(.N_ENT(N_ENT)) u_dbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en & ~wr_side), .wr_idx(wr_idx),
    .wr_desc(wr_desc), .descs(dbank)
  );

  assign bank_sel = acc_fetch ? ibank : dbank;
  assign xon      = acc_fetch ? itr_en : dtr_en;

  bat_match #(.N_ENT(N_ENT)) u_match (
    .descs(bank_sel), .tag(ea[EA_W-1:OFF_W]), .user(acc_user),
    .hit_vec(hit_vec)
  );

  bat_prio #(.N_ENT(N_ENT)) u_prio (
    .hit_vec(hit_vec), .win_vec(win_vec)
  );

  // One-hot AND-OR select of the winning descriptor.
  always_comb begin
    win_desc = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (win_vec[i]) win_desc = desc_t'(win_desc | bank_sel[i]);
    end
  end

  assign any_hit  = xon & (|win_vec);
  assign pa_nxt   = any_hit ? merge_pa(win_desc, ea) : ea;
  assign viol_nxt = any_hit & access_bad(win_desc.prot, acc_store, acc_fetch);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa   <= '0;
      hit  <= 1'b0;
      viol <= 1'b0;
    end else begin
      pa   <= pa_nxt;
      hit  <= any_hit;
      viol <= viol_nxt;
    end
  end
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk
  import bat_pkg::*;
#(
  parameter int N_ENT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [LEN_W-1:0]  wr_len,
  input logic              xon,
  input logic [EA_W-1:0]   ea,
  input logic [N_ENT-1:0]  hit_vec,
  input logic [N_ENT-1:0]  win_vec,
  input logic [EA_W-1:0]   pa,
  input logic              hit,
  input logic              viol
);
  // R3
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> len_legal(wr_len));

  // R2
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xon |=> (pa == $past(ea)) && !hit && !viol);

  // R5
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pa[OFF_W-1:0] == $past(ea[OFF_W-1:0]));

  // R8
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec) && ((win_vec & ~hit_vec) == '0)
    && ((hit_vec != '0) == (win_vec != '0))
    && ((hit_vec & N_ENT'(win_vec - 1'b1)) == '0));

  // R7
  viol_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> hit);

  // R11
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xon && hit_vec == '0) |=> (pa == $past(ea)) && !hit && !viol);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (pa == '0) && !hit && !viol);
endmodule

bind blk_xlate_unit xlate_chk #(.N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_len(wr_len), .xon(xon),
  .ea(ea), .hit_vec(hit_vec), .win_vec(win_vec), .pa(pa), .hit(hit),
  .viol(viol)
);

// File: tb/sim_blk_xlate_unit.sv
module sim_blk_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_side, wr_sv, wr_uv;
  logic [1:0]  wr_idx;
  logic [14:0] wr_lbase, wr_pbase;
  logic [10:0] wr_len;
  logic [1:0]  wr_prot;
  logic        itr_en, dtr_en, acc_fetch, acc_store, acc_user;
  logic [31:0] ea, pa;
  logic        hit, viol;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  blk_xlate_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side),
    .wr_idx(wr_idx), .wr_lbase(wr_lbase), .wr_pbase(wr_pbase),
    .wr_len(wr_len), .wr_sv(wr_sv), .wr_uv(wr_uv), .wr_prot(wr_prot),
    .itr_en(itr_en), .dtr_en(dtr_en), .acc_fetch(acc_fetch),
    .acc_store(acc_store), .acc_user(acc_user), .ea(ea), .pa(pa),
    .hit(hit), .viol(viol)
  );

  // Fields: req tag, fetch, store, user, itr_en, dtr_en, ea, hit, viol, pa
  localparam int NV = 15;
  localparam logic [74:0] VEC [NV] = '{
    {4'd8,  5'b00011, 32'h1000_1234, 2'b10, 32'h2000_1234}, // R8 D0 beats D1
    {4'd7,  5'b01111, 32'h1000_1234, 2'b10, 32'h2000_1234}, // R7 store to RW
    {4'd3,  5'b00011, 32'h1004_0010, 2'b10, 32'h4004_0010}, // R3 256MB region
    {4'd7,  5'b01011, 32'h1004_0010, 2'b11, 32'h4004_0010}, // R7 store to RO
    {4'd6,  5'b00111, 32'h1004_0010, 2'b00, 32'h1004_0010}, // R6 no user valid
    {4'd4,  5'b00111, 32'h801F_FFFC, 2'b10, 32'h601F_FFFC}, // R4 2MB merge
    {4'd3,  5'b00111, 32'h8020_0000, 2'b00, 32'h8020_0000}, // R3 outside 2MB
    {4'd7,  5'b00111, 32'hC000_0100, 2'b11, 32'hE000_0100}, // R7 no-access
    {4'd6,  5'b00011, 32'hC000_0100, 2'b00, 32'hC000_0100}, // R6 no sup valid
    {4'd2,  5'b00010, 32'h1000_1234, 2'b00, 32'h1000_1234}, // R2 data off
    {4'd9,  5'b11010, 32'h0007_FFF0, 2'b10, 32'h1007_FFF0}, // R9 fetch bank
    {4'd11, 5'b10010, 32'h0008_0000, 2'b00, 32'h0008_0000}, // R11 fetch miss
    {4'd2,  5'b10001, 32'h0000_0100, 2'b00, 32'h0000_0100}, // R2 fetch off
    {4'd9,  5'b10010, 32'h1000_1234, 2'b00, 32'h1000_1234}, // R9 no data bank
    {4'd5,  5'b00011, 32'h1001_FFFF, 2'b10, 32'h2001_FFFF}  // R5 low bits
  };

  task automatic chk(input string req, input logic [31:0] epa,
                     input logic eh, input logic ev);
    total++;
    if (pa !== epa || hit !== eh || viol !== ev) begin
      bad++;
      $display("FAIL %s: pa=%h hit=%b viol=%b expected pa=%h hit=%b viol=%b",
               req, pa, hit, viol, epa, eh, ev);
    end
  endtask

  task automatic wr_desc(input logic side, input logic [1:0] idx,
                         input logic [14:0] lb, input logic [14:0] pb,
                         input logic [10:0] len, input logic sv,
                         input logic uv, input logic [1:0] prot);
    @(negedge clk);
    wr_en = 1'b1; wr_side = side; wr_idx = idx; wr_lbase = lb;
    wr_pbase = pb; wr_len = len; wr_sv = sv; wr_uv = uv; wr_prot = prot;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic access(input logic f, input logic s, input logic u,
                        input logic ie, input logic de, input logic [31:0] a);
    @(negedge clk);
    acc_fetch = f; acc_store = s; acc_user = u; itr_en = ie; dtr_en = de;
    ea = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_side = 1'b0; wr_idx = '0;
    wr_lbase = '0; wr_pbase = '0; wr_len = '0; wr_sv = 1'b0; wr_uv = 1'b0;
    wr_prot = '0; itr_en = 1'b1; dtr_en = 1'b1; acc_fetch = 1'b0;
    acc_store = 1'b0; acc_user = 1'b0; ea = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty banks miss after reset
    access(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1000_1234);
    chk("R1 empty data bank", 32'h1000_1234, 1'b0, 1'b0);
    access(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0100);
    chk("R1 empty instr bank", 32'h0000_0100, 1'b0, 1'b0);

    // Data bank (wr_side=0) and instruction bank (wr_side=1)
    wr_desc(1'b0, 2'd0, 15'h0800, 15'h1000, 11'h000, 1'b1, 1'b1, 2'b10);
    wr_desc(1'b0, 2'd1, 15'h0800, 15'h2000, 11'h7FF, 1'b1, 1'b0, 2'b01);
    wr_desc(1'b0, 2'd2, 15'h4000, 15'h3000, 11'h00F, 1'b1, 1'b1, 2'b01);
    wr_desc(1'b0, 2'd3, 15'h6000, 15'h7000, 11'h000, 1'b0, 1'b1, 2'b00);
    wr_desc(1'b1, 2'd0, 15'h0000, 15'h0800, 11'h003, 1'b1, 1'b1, 2'b01);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][70], VEC[i][69], VEC[i][68], VEC[i][67], VEC[i][66],
             VEC[i][65:34]);
      total++;
      if (pa !== VEC[i][31:0] || hit !== VEC[i][33] || viol !== VEC[i][32]) begin
        bad++;
        $display("FAIL R%0d vec %0d: pa=%h hit=%b viol=%b expected pa=%h hit=%b viol=%b",
                 VEC[i][74:71], i, pa, hit, viol, VEC[i][31:0], VEC[i][33],
                 VEC[i][32]);
      end
    end

    // R10: a write and a lookup in the same cycle; the lookup sees old contents
    @(negedge clk);
    wr_en = 1'b1; wr_side = 1'b0; wr_idx = 2'd0; wr_lbase = 15'h0800;
    wr_pbase = 15'h1100; wr_len = 11'h000; wr_sv = 1'b1; wr_uv = 1'b1;
    wr_prot = 2'b10;
    acc_fetch = 1'b0; acc_store = 1'b0; acc_user = 1'b0; itr_en = 1'b1;
    dtr_en = 1'b1; ea = 32'h1000_1234;
    @(posedge clk);
    #1;
    chk("R10 old descriptor on write cycle", 32'h2000_1234, 1'b1, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk);
    #1;
    chk("R10 new descriptor next cycle", 32'h2200_1234, 1'b1, 1'b0);

    // R10: output follows access one clock later
    @(negedge clk);
    ea = 32'h8000_0004; acc_user = 1'b1;
    #1;
    chk("R10 output not yet updated", 32'h2200_1234, 1'b1, 1'b0);
    @(posedge clk);
    #1;
    chk("R10 output updated", 32'h6000_0004, 1'b1, 1'b0);

    // R1: reset reasserted clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 reset reasserted", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1000_1234);
    chk("R1 descriptors cleared", 32'h1000_1234, 1'b0, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule